// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable, reduced-depth model of a synchronous static RAM. Address, control and write data are captured on a rising clock edge and read data leaves through one more register. One presented address serves a burst of four data beats. The bus supplies the first address and an internal two-bit beat counter supplies the other three. A mode input picks a sequential or an XOR-based beat order.

A new burst starts on either of two address strobes. The processor-side strobe only acts while the primary enable is low. The controller-side strobe always acts. A strobe seen while the chip selects do not match deselects the part in one cycle. Writes use a global write, or a byte-write enable together with per-byte selects. A sleep input freezes the part while keeping its contents and its burst position. The bidirectional data pins are split into a write-data bus, a read-data bus and a drive-enable output.

Top module: `burst_sram`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it is released, `rdata_oe_o` is 0.
- R2: Read data for a beat registered on clock edge t is on `rdata_o`, with `rdata_oe_o` high (if `oe_n_i` is low), after edge t+1 and until edge t+2.
- R3: With `adv_n_i` low and no strobe, each edge moves to the next beat; after the fourth beat the order wraps to the first. With `adv_n_i` high, the same beat address is accessed again.
- R4: With `mode_lin_i` = 1 (sequential), beat k uses low address bits (start + k) mod 4; the upper address bits stay those of the start address.
- R5: With `mode_lin_i` = 0 (XOR order), beat k uses low address bits start XOR k.
- R6: `gw_n_i` low writes every byte lane of the current beat address from `wdata_i`, whatever `bwe_n_i` and `bw_n_i` are.
- R7: With `gw_n_i` high and `bwe_n_i` low, only lanes i with `bw_n_i[i]` = 0 are written; lane i is `wdata_i[9i+8:9i]`. With no lane selected, nothing changes.
- R8: A cycle with `gw_n_i` or `bwe_n_i` low produces no read beat. Only a cycle with both high is a read.
- R9: `sts_cpu_n_i` low is ignored while `ce_n_i` is high, so the current burst carries on. `sts_ctl_n_i` low loads a new address regardless of `ce_n_i`.
- R10: The part is selected only when `ce_n_i`=0, `cs0_i`=1 and `cs1_n_i`=0. A strobe load while not selected deselects it. From then on no beat is read or written until a selected load.
- R11: `rdata_oe_o` is high only while `oe_n_i` is low and a read beat is being presented.
- R12: In a cycle with `sleep_i` high, strobes, advance and writes are ignored and no beat is read. Memory contents and the burst position are retained for the cycles that follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Start address for a burst |
| ce_n_i | input | 1 | Primary enable, active low |
| cs0_i | input | 1 | Chip select, active high |
| cs1_n_i | input | 1 | Chip select, active low |
| sts_cpu_n_i | input | 1 | Processor-side address strobe, active low |
| sts_ctl_n_i | input | 1 | Controller-side address strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| gw_n_i | input | 1 | Global write, active low |
| bwe_n_i | input | 1 | Byte-write enable, active low |
| bw_n_i | input | LANES | Per-lane write selects, active low |
| oe_n_i | input | 1 | Output enable, active low |
| sleep_i | input | 1 | Power-down request, active high |
| mode_lin_i | input | 1 | Beat order: 1 sequential, 0 XOR |
| wdata_i | input | LANES*LANE_W | Write data |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rdata_oe_o | output | 1 | High while the data pins would be driven |

## Verification
The hardest case to reach from the ports is a sleep cycle in the middle of a burst. The same cycle also carries a live strobe, an advance and a write, and the burst must then resume at the retained beat with memory untouched. The stimulus sets this up with a directed sequence. It is followed by reads that show the skipped beat and the unchanged locations. A deselect followed by writes with the advance held low is covered the same way. A long pseudo-random phase then mixes strobes, selects, modes, sleep and output enable over a fully written address window. A reference model predicts every output beat for it.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  typedef enum logic {
    ORD_XOR    = 1'b0,
    ORD_SEQ    = 1'b1
  } beat_order_e;

  // Low two address bits of beat k for a burst starting at 'start'.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] k,
                                          input beat_order_e ord);
    if (ord == ORD_SEQ) return start + k;
    return start ^ k;
  endfunction

endpackage

// File: rtl/burst_seq.sv
module burst_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              cs0_i,
  input  logic              cs1_n_i,
  input  logic              sts_cpu_n_i,
  input  logic              sts_ctl_n_i,
  input  logic              adv_n_i,
  input  logic              mode_lin_i,
  output logic              acc_o,
  output logic [ADDR_W-1:0] ea_o
);

  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              sel, load, adv;
  beat_order_e       ord;

  always_comb begin
    sel      = !ce_n_i && cs0_i && !cs1_n_i;
    load     = !sleep_i && ((!sts_cpu_n_i && !ce_n_i) || !sts_ctl_n_i);
    adv      = !sleep_i && !load && active_q && !adv_n_i;
    active_d = load ? sel : active_q;
    base_d   = (load && sel) ? addr_i : base_q;
    if (load)     cnt_d = 2'd0;
    else if (adv) cnt_d = cnt_q + 2'd1;
    else          cnt_d = cnt_q;
    ord      = mode_lin_i ? ORD_SEQ : ORD_XOR;
    ea_o     = {base_d[ADDR_W-1:2], beat_low(base_d[1:0], cnt_d, ord)};
    acc_o    = !sleep_i && active_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= 2'd0;
    end else if (!sleep_i) begin
      active_q <= active_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/burst_stage.sv
module burst_stage #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  bw_n_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [ADDR_W-1:0] st_addr_o,
  output logic [LANES-1:0]  st_we_o,
  output logic              st_re_o,
  output logic [DATA_W-1:0] st_wdata_o
);

  logic             is_wr;
  logic [LANES-1:0] lane_mask;

  always_comb begin
    is_wr = !gw_n_i || !bwe_n_i;
    if (!gw_n_i)       lane_mask = '1;
    else if (!bwe_n_i) lane_mask = ~bw_n_i;
    else               lane_mask = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_re_o <= 1'b0;
      st_we_o <= '0;
    end else begin
      st_re_o <= acc_i && !is_wr;
      st_we_o <= acc_i ? lane_mask : '0;
    end
    st_addr_o  <= ea_i;
    st_wdata_o <= wdata_i;
  end

endmodule

// File: rtl/burst_mem.sv
module burst_mem #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  we_i,
  input  logic              re_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] ram [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (we_i[g]) ram[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
      if (re_i)    q <= ram[addr_i];
    end

    assign rdata_o[g*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk) begin
    if (rst) rvalid_o <= 1'b0;
    else     rvalid_o <= re_i;
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_n_i,
  input  logic              cs0_i,
  input  logic              cs1_n_i,
  input  logic              sts_cpu_n_i,
  input  logic              sts_ctl_n_i,
  input  logic              adv_n_i,
  input  logic              gw_n_i,
  input  logic              bwe_n_i,
  input  logic [LANES-1:0]  bw_n_i,
  input  logic              oe_n_i,
  input  logic              sleep_i,
  input  logic              mode_lin_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rdata_oe_o
);

  logic              acc;
  logic [ADDR_W-1:0] ea;
  logic [ADDR_W-1:0] st_addr;
  logic [LANES-1:0]  st_we;
  logic              st_re;
  logic [DATA_W-1:0] st_wdata;
  logic              rvalid;

  burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .sleep_i     (sleep_i),
    .addr_i      (addr_i),
    .ce_n_i      (ce_n_i),
    .cs0_i       (cs0_i),
    .cs1_n_i     (cs1_n_i),
    .sts_cpu_n_i (sts_cpu_n_i),
    .sts_ctl_n_i (sts_ctl_n_i),
    .adv_n_i     (adv_n_i),
    .mode_lin_i  (mode_lin_i),
    .acc_o       (acc),
    .ea_o        (ea)
  );

  burst_stage #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_stage (
    .clk        (clk),
    .rst        (rst),
    .acc_i      (acc),
    .ea_i       (ea),
    .gw_n_i     (gw_n_i),
    .bwe_n_i    (bwe_n_i),
    .bw_n_i     (bw_n_i),
    .wdata_i    (wdata_i),
    .st_addr_o  (st_addr),
    .st_we_o    (st_we),
    .st_re_o    (st_re),
    .st_wdata_o (st_wdata)
  );

  burst_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk      (clk),
    .rst      (rst),
    .addr_i   (st_addr),
    .we_i     (st_we),
    .re_i     (st_re),
    .wdata_i  (st_wdata),
    .rdata_o  (rdata_o),
    .rvalid_o (rvalid)
  );

  assign rdata_oe_o = rvalid && !oe_n_i;

endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
  input logic clk,
  input logic rst,
  input logic sleep_i,
  input logic ce_n_i,
  input logic cs0_i,
  input logic cs1_n_i,
  input logic sts_ctl_n_i,
  input logic gw_n_i,
  input logic bwe_n_i,
  input logic rdata_oe_o
);

  // R1: first cycle out of reset never drives
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !rdata_oe_o);

  // R8: a write cycle yields no read beat two edges later
  a_r8_write_no_drive: assert property (@(posedge clk) disable iff (rst)
    (!gw_n_i || !bwe_n_i) |=> ##1 !rdata_oe_o);

  // R12: a sleep cycle yields no read beat
  a_r12_sleep_no_drive: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> ##1 !rdata_oe_o);

  // R10: an unselected controller-strobe load deselects
  a_r10_deselect: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !sts_ctl_n_i && !(!ce_n_i && cs0_i && !cs1_n_i))
      |=> ##1 !rdata_oe_o);

endmodule

bind burst_sram burst_sram_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .sleep_i     (sleep_i),
  .ce_n_i      (ce_n_i),
  .cs0_i       (cs0_i),
  .cs1_n_i     (cs1_n_i),
  .sts_ctl_n_i (sts_ctl_n_i),
  .gw_n_i      (gw_n_i),
  .bwe_n_i     (bwe_n_i),
  .rdata_oe_o  (rdata_oe_o)
);

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
  localparam int AW = 8;
  localparam int LN = 2;
  localparam int LW = 9;
  localparam int DW = LN * LW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b0, cs0 = 1'b1, cs1_n = 1'b0;
  logic cpu_n = 1'b1, ctl_n = 1'b1, adv_n = 1'b1;
  logic gw_n = 1'b1, bwe_n = 1'b1;
  logic [LN-1:0] bw_n = '1;
  logic oe_n = 1'b0, sleep = 1'b0, mode = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int checks = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) u_dut (
    .clk(clk), .rst(rst), .addr_i(addr), .ce_n_i(ce_n), .cs0_i(cs0),
    .cs1_n_i(cs1_n), .sts_cpu_n_i(cpu_n), .sts_ctl_n_i(ctl_n),
    .adv_n_i(adv_n), .gw_n_i(gw_n), .bwe_n_i(bwe_n), .bw_n_i(bw_n),
    .oe_n_i(oe_n), .sleep_i(sleep), .mode_lin_i(mode), .wdata_i(wdata),
    .rdata_o(rdata), .rdata_oe_o(rdata_oe)
  );

  typedef struct {
    logic          vld;
    logic [DW-1:0] dat;
    string         tag;
  } exp_t;
  exp_t sb[$];

  // reference state
  logic [DW-1:0] m_mem [1<<AW];
  logic          m_act = 1'b0;
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = 2'd0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a, logic [7:0] s);
    return {1'b1, a ^ s, 1'b0, ~a};
  endfunction

  task automatic idle();
    ctl_n = 1'b1; cpu_n = 1'b1; adv_n = 1'b1;
    gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; sleep = 1'b0;
  endtask

  // one clock; reference model follows the requirements
  task automatic step(string tag);
    logic sel, ld, stp, acc, wr;
    logic [1:0] lo;
    logic [AW-1:0] ea;
    exp_t it;
    @(posedge clk);
    sel = !ce_n && cs0 && !cs1_n;
    ld  = !sleep && ((!cpu_n && !ce_n) || !ctl_n);
    stp = !sleep && !ld && m_act && !adv_n;
    if (!sleep) begin
      if (ld) begin
        m_act = sel;
        m_cnt = 2'd0;
        if (sel) m_base = addr;
      end else if (stp) m_cnt = m_cnt + 2'd1;
    end
    acc = !sleep && m_act;
    wr  = !gw_n || !bwe_n;
    lo  = mode ? m_base[1:0] + m_cnt : m_base[1:0] ^ m_cnt;
    ea  = {m_base[AW-1:2], lo};
    it.vld = 1'b0; it.dat = '0; it.tag = tag;
    if (acc && wr) begin
      for (int i = 0; i < LN; i++)
        if (!gw_n || !bw_n[i]) m_mem[ea][i*LW +: LW] = wdata[i*LW +: LW];
    end else if (acc) begin
      it.vld = 1'b1;
      it.dat = m_mem[ea];
    end
    sb.push_back(it);
    #1;
  endtask

  // monitor: item pushed at edge t is visible after edge t+1
  always @(negedge clk) begin
    if (!rst && sb.size() >= 2) begin
      exp_t it;
      logic eo;
      it = sb.pop_front();
      eo = it.vld && !oe_n;
      chk({it.tag, " drive"}, {31'd0, rdata_oe}, {31'd0, eo});
      if (eo) chk({it.tag, " data"}, {14'd0, rdata}, {14'd0, it.dat});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    idle();
    // R1: reset
    repeat (3) begin
      @(negedge clk);
      chk("R1 in reset", {31'd0, rdata_oe}, 32'd0);
    end
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", {31'd0, rdata_oe}, 32'd0);
    @(posedge clk); #1;

    // fill 0x10..0x1F with global writes, sequential order (R6, R3)
    mode = 1'b1;
    for (int b = 0; b < 4; b++) begin
      idle(); ctl_n = 1'b0; addr = 8'h10 + 8'(b*4); gw_n = 1'b0;
      bwe_n = 1'b0; bw_n = '1;
      wdata = pat(addr, 8'h00); step("R6");
      for (int k = 1; k < 4; k++) begin
        idle(); adv_n = 1'b0; gw_n = 1'b0;
        wdata = pat(8'h10 + 8'(b*4 + k), 8'h00); step("R6");
      end
    end

    // sequential burst from 0x12, then wrap (R2, R3, R4)
    idle(); ctl_n = 1'b0; addr = 8'h12; step("R4");
    for (int k = 0; k < 4; k++) begin idle(); adv_n = 1'b0; step("R3"); end
    idle(); step("R3 hold"); step("R3 hold");

    // XOR burst from 0x17 (R5)
    mode = 1'b0;
    idle(); ctl_n = 1'b0; addr = 8'h17; step("R5");
    for (int k = 0; k < 3; k++) begin idle(); adv_n = 1'b0; step("R5"); end

    // byte writes at 0x19 (R7), none-selected cycle, global over byte (R6)
    mode = 1'b1;
    idle(); ctl_n = 1'b0; addr = 8'h19; bwe_n = 1'b0; bw_n = 2'b10;
    wdata = 18'h2AB55; step("R7");
    idle(); adv_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b01; wdata = 18'h1C3C3;
    step("R7");
    idle(); adv_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b11; wdata = 18'h3FFFF;
    step("R8");
    idle(); adv_n = 1'b0; gw_n = 1'b0; bwe_n = 1'b0; bw_n = 2'b11;
    wdata = 18'h0F0F0; step("R6");
    idle(); ctl_n = 1'b0; addr = 8'h19; step("R7");
    for (int k = 0; k < 3; k++) begin idle(); adv_n = 1'b0; step("R7"); end

    // processor strobe ignored with ce_n high (R9)
    idle(); ctl_n = 1'b0; addr = 8'h14; step("R9");
    idle(); ce_n = 1'b1; cpu_n = 1'b0; addr = 8'h00; adv_n = 1'b0; step("R9");
    idle(); ce_n = 1'b0; cpu_n = 1'b0; addr = 8'h1E; mode = 1'b0; step("R9");
    for (int k = 0; k < 3; k++) begin idle(); adv_n = 1'b0; step("R9"); end
    mode = 1'b1;

    // deselect then ignored writes (R10)
    idle(); ctl_n = 1'b0; cs0 = 1'b0; addr = 8'h10; step("R10");
    cs0 = 1'b1;
    for (int k = 0; k < 3; k++) begin
      idle(); adv_n = 1'b0; gw_n = 1'b0; wdata = 18'h00000; step("R10");
    end
    idle(); ctl_n = 1'b0; ce_n = 1'b1; addr = 8'h10; step("R10");
    ce_n = 1'b0;
    idle(); ctl_n = 1'b0; addr = 8'h10; step("R10");
    for (int k = 0; k < 3; k++) begin idle(); adv_n = 1'b0; step("R10"); end

    // output enable (R11)
    idle(); ctl_n = 1'b0; addr = 8'h1C; step("R11");
    idle(); adv_n = 1'b0; oe_n = 1'b1; step("R11");
    idle(); adv_n = 1'b0; step("R11");
    oe_n = 1'b0;
    idle(); adv_n = 1'b0; step("R11");

    // sleep mid-burst with live strobe and write (R12)
    idle(); ctl_n = 1'b0; addr = 8'h14; step("R12");
    idle(); adv_n = 1'b0; step("R12");
    idle(); sleep = 1'b1; adv_n = 1'b0; ctl_n = 1'b0; addr = 8'h1F;
    gw_n = 1'b0; wdata = 18'h12345; step("R12");
    idle(); adv_n = 1'b0; step("R12");
    idle(); adv_n = 1'b0; step("R12");
    idle(); adv_n = 1'b0; step("R12");

    // pseudo-random mix over the written window (R2)
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom;
      idle();
      ctl_n = (r[3:0] == 0);
      ctl_n = !ctl_n;
      cpu_n = !(r[7:4] == 1);
      ce_n  = (r[11:8] == 2);
      cs0   = !(r[15:12] == 3);
      cs1_n = 1'b0;
      adv_n = r[16];
      gw_n  = !(r[20:18] == 0);
      bwe_n = !(r[20:18] == 1);
      bw_n  = r[22:21];
      sleep = (r[26:23] == 4);
      oe_n  = (r[29:27] == 5);
      mode  = r[30];
      addr  = 8'h10 | 8'(r[19:16] ^ r[27:24]);
      wdata = DW'($urandom);
      step("R2");
    end
    ce_n = 1'b0; cs0 = 1'b1; oe_n = 1'b0;
    idle(); ctl_n = 1'b0; cs0 = 1'b0; step("R10");
    cs0 = 1'b1;
    idle(); step("R10"); step("R10");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule